// File: doc/BRIEF.md
# CAN Controller Command and Interrupt Unit

This block is the control register front end of a CAN-style controller. It sits between a byte-wide register bus and a separate bit-level protocol engine, which this block does not contain. Software uses it for four things: choosing the operating mode, issuing transmit and receive-buffer commands, reading buffer status, and taking interrupts. The protocol engine reports frame completion and error conditions as single-cycle strobes. In return it receives mode levels and one-cycle command pulses.

The block holds a mode register and an interrupt enable register. It also holds three byte registers for the error counters and the warning limit. A transmit-buffer-available flag goes low while a transmission is pending. Interrupt causes are latched in a raw register, and reading that register clears it. The single interrupt line is a registered OR of the raw causes masked by the enable register. While the mode reset bit is set, command writes have no effect.

Register map (3-bit address): 0 mode, 1 command (write only, reads 0), 2 status, 3 raw interrupt, 4 interrupt enable, 5 transmit error count, 6 receive error count, 7 warning limit. Reads are registered: `bus_rdata` shows the value one clock edge after `bus_rd` is sampled.

Top module: `can_cmd_irq`

## Requirements
- R1: After reset the registers read as follows: mode = 0x01, status = 0x04, raw = 0x00, enable = 0xE7, transmit error count = 0, receive error count = 0, warning limit = 96 (0x60). The command address reads 0x00 and `irq` is 0.
- R2: Mode bits: bit0 is reset, bit1 is listen-only, bit2 is self-test and bit3 is single-filter. The bits read back as written and drive `mode_reset`, `mode_listen`, `mode_selftest` and `mode_single_filt`.
- R3: While mode bit0 is 1, a command write produces no pulse and changes no status bit.
- R4: Command bit0 (transmit request) is acted on only when status bit2 (buffer available) is 1. It then pulses `tx_start` for one cycle and clears status bit2. When no buffer is available the request is ignored.
- R5: Command bit4 (self-reception request) starts a transmission under the same rule as R4, pulsing `self_rx_start` instead of `tx_start`.
- R6: Command bit1 (abort) is acted on only while a transmission is pending. It pulses `tx_abort`, sets status bit2 and sets raw bit1, but does not set status bit3. If one write carries both request and abort, the buffer state before the write decides: a free buffer starts the transmission, a busy one is aborted.
- R7: `ev_tx_done` while a transmission is pending sets status bit2, status bit3 (transmit complete) and raw bit1.
- R8: `ev_rx_done` sets raw bit0 and status bit0 (frame held). If a frame is already held, it also sets status bit1 (overrun) and raw bit3. Command bit2 (release) clears status bit0, and command bit3 clears status bit1. A release in the same cycle as a new frame leaves status bit0 set and causes no overrun.
- R9: Reading the raw register returns the latched causes and clears them. A cause that arrives in the same cycle as the read stays latched. Raw bit2 is set by `ev_err_warn`, bit4 by `ev_presc`, bit5 by `ev_err_passive`, bit6 by `ev_arb_lost` and bit7 by `ev_bus_err`.
- R10: Reading the status register clears status bit3 only.
- R11: `irq` equals the OR of (raw AND enable) as it stood one clock earlier.
- R12: The error counts and the warning limit can be written and read back at any time.
- R13: Writing mode with bit0 set while a transmission is pending makes the buffer available again without raising an interrupt cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ev_tx_done | input | 1 | Transmission finished strobe |
| ev_rx_done | input | 1 | Frame received strobe |
| ev_err_warn | input | 1 | Error warning strobe |
| ev_presc | input | 1 | Prescaler divide flag strobe |
| ev_err_passive | input | 1 | Error passive strobe |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| ev_bus_err | input | 1 | Bus error strobe |
| mode_reset | output | 1 | Controller held in reset mode |
| mode_listen | output | 1 | Listen-only mode |
| mode_selftest | output | 1 | Self-test mode |
| mode_single_filt | output | 1 | Single acceptance filter mode |
| tx_start | output | 1 | One-cycle transmit start pulse |
| tx_abort | output | 1 | One-cycle abort pulse |
| self_rx_start | output | 1 | One-cycle self-reception start pulse |
| irq | output | 1 | Level interrupt |

## Verification
Register updates, command pulses and read data all appear at the first clock edge after the strobe that causes them. The interrupt line follows one edge later. The bench drives every stimulus for exactly one cycle starting at a falling edge, then samples at the next falling edge. A result that depends on `irq` gets one extra falling edge before it is checked, and the cycle before that is checked too, to confirm the one-cycle lag. The same-cycle collisions are driven in a single cycle: a read of the raw register together with a new cause, and a release together with a new frame.

// File: rtl/can_cmd_irq.sv
module can_cmd_irq #(
  parameter int          ADDR_W   = 3,
  parameter logic [7:0]  IEN_INIT = 8'hE7,
  parameter logic [7:0]  EWL_INIT = 8'd96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_err_warn,
  input  logic              ev_presc,
  input  logic              ev_err_passive,
  input  logic              ev_arb_lost,
  input  logic              ev_bus_err,
  output logic              mode_reset,
  output logic              mode_listen,
  output logic              mode_selftest,
  output logic              mode_single_filt,
  output logic              tx_start,
  output logic              tx_abort,
  output logic              self_rx_start,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TEC  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_REC  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_EWL  = ADDR_W'(7);

  logic [3:0] mode_q;
  logic [7:0] ien_q, raw_q, tec_q, rec_q, ewl_q, rdata_q;
  logic       tx_avail_q, tx_cpl_q, rx_pend_q, ovr_q;
  logic       start_q, abort_q, selfrx_q, irq_q;

  wire cmd_ok    = bus_wr && bus_addr == A_CMD && !mode_q[0];
  wire mode_wr   = bus_wr && bus_addr == A_MODE;
  wire start_ok  = cmd_ok && (bus_wdata[0] || bus_wdata[4]) && tx_avail_q;
  wire abort_ok  = cmd_ok && bus_wdata[1] && !tx_avail_q;
  wire release_c = cmd_ok && bus_wdata[2];
  wire clr_ovr   = cmd_ok && bus_wdata[3];
  wire done_ok   = ev_tx_done && !tx_avail_q;
  wire ovr_evt   = ev_rx_done && rx_pend_q && !release_c;
  wire raw_rd    = bus_rd && bus_addr == A_RAW;
  wire stat_rd   = bus_rd && bus_addr == A_STAT;

  wire [7:0] raw_set = {ev_bus_err, ev_arb_lost, ev_err_passive, ev_presc,
                        ovr_evt, ev_err_warn, done_ok || abort_ok, ev_rx_done};
  wire [7:0] status  = {4'b0, tx_cpl_q, tx_avail_q, ovr_q, rx_pend_q};

  logic [7:0] rd_mux;
  always_comb begin
    case (bus_addr)
      A_MODE:  rd_mux = {4'b0, mode_q};
      A_STAT:  rd_mux = status;
      A_RAW:   rd_mux = raw_q;
      A_IEN:   rd_mux = ien_q;
      A_TEC:   rd_mux = tec_q;
      A_REC:   rd_mux = rec_q;
      A_EWL:   rd_mux = ewl_q;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 4'b0001;
      ien_q      <= IEN_INIT;
      tec_q      <= 8'd0;
      rec_q      <= 8'd0;
      ewl_q      <= EWL_INIT;
      rdata_q    <= 8'd0;
      raw_q      <= 8'd0;
      tx_avail_q <= 1'b1;
      tx_cpl_q   <= 1'b0;
      rx_pend_q  <= 1'b0;
      ovr_q      <= 1'b0;
      start_q    <= 1'b0;
      abort_q    <= 1'b0;
      selfrx_q   <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= bus_wdata[3:0];
      if (bus_wr && bus_addr == A_IEN) ien_q <= bus_wdata;
      if (bus_wr && bus_addr == A_TEC) tec_q <= bus_wdata;
      if (bus_wr && bus_addr == A_REC) rec_q <= bus_wdata;
      if (bus_wr && bus_addr == A_EWL) ewl_q <= bus_wdata;
      if (bus_rd) rdata_q <= rd_mux;

      raw_q <= (raw_rd ? 8'h00 : raw_q) | raw_set;

      if (start_ok)
        tx_avail_q <= 1'b0;
      else if (abort_ok || done_ok || (mode_wr && bus_wdata[0]))
        tx_avail_q <= 1'b1;

      if (done_ok)      tx_cpl_q <= 1'b1;
      else if (stat_rd) tx_cpl_q <= 1'b0;

      if (ev_rx_done)     rx_pend_q <= 1'b1;
      else if (release_c) rx_pend_q <= 1'b0;

      if (ovr_evt)      ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;

      start_q  <= start_ok && bus_wdata[0];
      selfrx_q <= start_ok && bus_wdata[4];
      abort_q  <= abort_ok;
      irq_q    <= |(raw_q & ien_q);
    end
  end

  assign bus_rdata        = rdata_q;
  assign mode_reset       = mode_q[0];
  assign mode_listen      = mode_q[1];
  assign mode_selftest    = mode_q[2];
  assign mode_single_filt = mode_q[3];
  assign tx_start         = start_q;
  assign tx_abort         = abort_q;
  assign self_rx_start    = selfrx_q;
  assign irq              = irq_q;

  a_r3_cmd_ignored_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CMD && mode_q[0]) |=> (!tx_start && !tx_abort && !self_rx_start));

  a_r4_start_takes_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start || self_rx_start) |-> !tx_avail_q);

  a_r6_start_abort_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_start, tx_abort}));

  a_r8_overrun_on_held_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_done && rx_pend_q && !(cmd_ok && bus_wdata[2])) |=> (ovr_q && raw_q[3]));

  a_r9_raw_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_rd && !ev_rx_done && !ev_tx_done && !ev_err_warn && !ev_presc &&
     !ev_err_passive && !ev_arb_lost && !ev_bus_err && !cmd_ok) |=> (raw_q == 8'h00));

  a_r11_irq_lags_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(raw_q & ien_q)));
endmodule

// File: tb/sim_can_cmd_irq.sv
module sim_can_cmd_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [6:0] ev = 7'd0;
  logic       mode_reset, mode_listen, mode_selftest, mode_single_filt;
  logic       tx_start, tx_abort, self_rx_start, irq;
  int         checks = 0, failures = 0;
  logic       p_start, p_abort, p_self;
  logic [7:0] rv;

  always #10 clk = ~clk;

  can_cmd_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_tx_done(ev[0]), .ev_rx_done(ev[1]), .ev_err_warn(ev[2]),
    .ev_presc(ev[3]), .ev_err_passive(ev[4]), .ev_arb_lost(ev[5]),
    .ev_bus_err(ev[6]),
    .mode_reset(mode_reset), .mode_listen(mode_listen),
    .mode_selftest(mode_selftest), .mode_single_filt(mode_single_filt),
    .tx_start(tx_start), .tx_abort(tx_abort), .self_rx_start(self_rx_start),
    .irq(irq));

  localparam logic [6:0] E_TX = 7'h01, E_RX = 7'h02, E_WARN = 7'h04,
                         E_ARB = 7'h20, E_BUS = 7'h40;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    p_start = tx_start; p_abort = tx_abort; p_self = self_rx_start;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = 7'd0;
  endtask

  task automatic t_reset();
    rd(3'd0, rv); chk("R1 mode", rv, 8'h01);
    rd(3'd1, rv); chk("R1 cmd", rv, 8'h00);
    rd(3'd2, rv); chk("R1 status", rv, 8'h04);
    rd(3'd3, rv); chk("R1 raw", rv, 8'h00);
    rd(3'd4, rv); chk("R1 enable", rv, 8'hE7);
    rd(3'd5, rv); chk("R1 tec", rv, 8'h00);
    rd(3'd6, rv); chk("R1 rec", rv, 8'h00);
    rd(3'd7, rv); chk("R1 ewl", rv, 8'h60);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_cmd_in_reset();
    wr(3'd1, 8'h11);
    chk("R3 no tx_start", {7'd0, p_start}, 8'h00);
    chk("R3 no self_rx", {7'd0, p_self}, 8'h00);
    rd(3'd2, rv); chk("R3 status", rv, 8'h04);
  endtask

  task automatic t_mode();
    wr(3'd0, 8'h0E);
    chk("R2 outs", {4'd0, mode_single_filt, mode_selftest, mode_listen, mode_reset}, 8'h0E);
    rd(3'd0, rv); chk("R2 readback", rv, 8'h0E);
    wr(3'd0, 8'h00);
    chk("R2 operating", {4'd0, mode_single_filt, mode_selftest, mode_listen, mode_reset}, 8'h00);
  endtask

  task automatic t_tx();
    wr(3'd1, 8'h01);
    chk("R4 tx_start", {7'd0, p_start}, 8'h01);
    @(negedge clk); chk("R4 one cycle", {7'd0, tx_start}, 8'h00);
    rd(3'd2, rv); chk("R4 busy", rv, 8'h00);
    wr(3'd1, 8'h01);
    chk("R4 ignored busy", {7'd0, p_start}, 8'h00);
    pulse(E_TX);
    chk("R11 lag", {7'd0, irq}, 8'h00);
    @(negedge clk); chk("R11 irq up", {7'd0, irq}, 8'h01);
    rd(3'd2, rv); chk("R7 status", rv, 8'h0C);
    rd(3'd2, rv); chk("R10 cpl cleared", rv, 8'h04);
    rd(3'd3, rv); chk("R7 raw tx", rv, 8'h02);
    @(negedge clk); chk("R11 irq down", {7'd0, irq}, 8'h00);
    rd(3'd3, rv); chk("R9 cleared", rv, 8'h00);
  endtask

  task automatic t_self_abort();
    wr(3'd1, 8'h10);
    chk("R5 self pulse", {6'd0, p_self, p_start}, 8'h02);
    rd(3'd2, rv); chk("R5 busy", rv, 8'h00);
    wr(3'd1, 8'h03);
    chk("R6 abort wins busy", {6'd0, p_abort, p_start}, 8'h02);
    rd(3'd2, rv); chk("R6 status no cpl", rv, 8'h04);
    rd(3'd3, rv); chk("R6 raw", rv, 8'h02);
    wr(3'd1, 8'h03);
    chk("R6 start wins free", {6'd0, p_abort, p_start}, 8'h01);
    pulse(E_TX);
    rd(3'd2, rv); rd(3'd3, rv);
  endtask

  task automatic t_rx();
    pulse(E_RX);
    rd(3'd2, rv); chk("R8 held", rv, 8'h05);
    rd(3'd3, rv); chk("R8 raw rx", rv, 8'h01);
    pulse(E_RX);
    rd(3'd2, rv); chk("R8 overrun", rv, 8'h07);
    rd(3'd3, rv); chk("R8 raw ovr", rv, 8'h09);
    wr(3'd1, 8'h08);
    rd(3'd2, rv); chk("R8 clr ovr", rv, 8'h05);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h04; ev = E_RX;
    @(negedge clk); bus_wr = 1'b0; ev = 7'd0;
    rd(3'd2, rv); chk("R8 release+frame", rv, 8'h05);
    wr(3'd1, 8'h04);
    rd(3'd2, rv); chk("R8 released", rv, 8'h04);
    rd(3'd3, rv); chk("R8 raw no ovr", rv, 8'h01);
  endtask

  task automatic t_collide();
    pulse(E_WARN);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd3; ev = E_ARB;
    @(negedge clk); bus_rd = 1'b0; ev = 7'd0;
    chk("R9 read value", bus_rdata, 8'h04);
    rd(3'd3, rv); chk("R9 late cause kept", rv, 8'h40);
  endtask

  task automatic t_mask();
    wr(3'd4, 8'h00);
    pulse(E_BUS);
    @(negedge clk); chk("R11 masked", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h80);
    chk("R11 enable lag", {7'd0, irq}, 8'h00);
    @(negedge clk); chk("R11 enabled", {7'd0, irq}, 8'h01);
    rd(3'd3, rv); chk("R9 bus err", rv, 8'h80);
    wr(3'd4, 8'hE7);
  endtask

  task automatic t_counters();
    wr(3'd5, 8'h7F); wr(3'd6, 8'h12); wr(3'd7, 8'h80);
    rd(3'd5, rv); chk("R12 tec", rv, 8'h7F);
    rd(3'd6, rv); chk("R12 rec", rv, 8'h12);
    rd(3'd7, rv); chk("R12 ewl", rv, 8'h80);
  endtask

  task automatic t_reset_abort();
    wr(3'd1, 8'h01);
    rd(3'd2, rv); chk("R13 pending", rv, 8'h00);
    wr(3'd0, 8'h01);
    chk("R13 no abort pulse", {7'd0, p_abort}, 8'h00);
    rd(3'd2, rv); chk("R13 freed", rv, 8'h04);
    rd(3'd3, rv); chk("R13 no cause", rv, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd_in_reset();
    t_mode();
    t_tx();
    t_self_abort();
    t_rx();
    t_collide();
    t_mask();
    t_counters();
    t_reset_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule